// File: doc/BRIEF.md
# Subrange Binary-to-Residue Converter

This block turns an unsigned binary word of `IN_W` bits into its remainder modulo a fixed modulus `MODULUS`. It feeds the per-modulus channel of a residue-number-system datapath, such as a filter that works on residues instead of positional words. Each input word is split into two equal halves. The upper half picks one of 2^(IN_W/2) subranges of consecutive values. The lower half is the offset inside that subrange.

A table indexed by the upper half holds the remainder of that subrange's first value. A second small table holds the offset's own remainder. The two remainders are added, and one conditional subtraction of the modulus brings the sum back into range. Both tables are computed at elaboration time from the parameters.

The converter is a fixed three-stage pipeline. It takes one word per clock with a valid flag and delivers each remainder three clocks later with its own valid flag. The latency is the same for every input width.

Top module: `subrangeResidue`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls with no input given, `validOut` is 0 and `residueOut` is 0.
- R2: For every word accepted with `validIn` high, the matching result on `residueOut` equals `dataIn mod MODULUS`.
- R3: `validOut` is high exactly in the cycle three rising edges after a rising edge that sampled `validIn` high. The latency does not depend on `IN_W`.
- R4: Words presented on consecutive cycles are all accepted. Their results come out on consecutive cycles, in the order the words went in.
- R5: Whenever `validOut` is high, `residueOut` is less than `MODULUS`.
- R6: When `validOut` is low, `residueOut` keeps the last result. A `dataIn` value sampled while `validIn` is low changes nothing at the outputs.
- R7: The input 0, the input 2^IN_W − 1, and every multiple of `MODULUS` give the correct remainder. A multiple gives 0. With the default parameters, 65535 = 17·3855 also gives 0.
- R8: The conversion is also correct when `MODULUS` is larger than 2^(IN_W/2). In that case successive subrange starts differ by a constant 2^(IN_W/2).
- R9: An input whose lower half is zero and whose upper half is H yields (H·2^(IN_W/2)) mod `MODULUS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| validIn | input | 1 | `dataIn` holds a word to convert this cycle |
| dataIn | input | IN_W | Unsigned binary word |
| validOut | output | 1 | `residueOut` holds a new result this cycle |
| residueOut | output | $clog2(MODULUS) | Remainder of the word modulo `MODULUS` |

## Verification
The bench builds two instances and drives them with the same stimulus.

The first instance uses the default width of 16 bits and modulus 17, which is smaller than the 256-entry subrange size. This instance receives every subrange start and the word corners. It also receives a long run of back-to-back random words.

The second instance is 8 bits wide with modulus 23, which is larger than its 16-entry subrange size. This brings the constant-shift case within reach, and the low-byte sweep covers that instance's entire input space.

// File: rtl/srrPkg.sv
package srrPkg;

  // Capture strobes passed from control to datapath, one per pipeline stage.
  typedef struct packed {
    logic capTable;  // stage 1: latch both table reads
    logic capSum;    // stage 2: latch the raw sum
    logic capFold;   // stage 3: latch the folded remainder
  } srrStrobe_t;

  // Computes (idx * 2^shiftBy) mod modv while keeping intermediates small.
  function automatic longint scaledMod(longint idx, int shiftBy, longint modv);
    longint weight;
    weight = 1;
    for (int k = 0; k < shiftBy; k++) begin
      weight = (weight * 2) % modv;
    end
    return ((idx % modv) * weight) % modv;
  endfunction

endpackage

// File: rtl/srrTable.sv
module srrTable #(
  parameter int ADDR_W  = 8,
  parameter int RES_W   = 5,
  parameter int MODULUS = 17,
  parameter int SHIFT   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [RES_W-1:0]  data
);
  import srrPkg::*;

  localparam int DEPTH = 2 ** ADDR_W;

  logic [RES_W-1:0] romArr [DEPTH];

  // Each entry is filled from the elaboration-time function.
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign romArr[i] = RES_W'(scaledMod(longint'(i), SHIFT, longint'(MODULUS)));
  end

  assign data = romArr[addr];

endmodule

// File: rtl/srrCtrl.sv
module srrCtrl #(
  parameter int STAGES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               validIn,
  output srrPkg::srrStrobe_t strobe,
  output logic               validOut
);
  logic [STAGES-1:0] stageValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageValid <= '0;
    end else begin
      stageValid <= {stageValid[STAGES-2:0], validIn};
    end
  end

  always_comb begin
    strobe.capTable = validIn;
    strobe.capSum   = stageValid[0];
    strobe.capFold  = stageValid[1];
  end

  assign validOut = stageValid[STAGES-1];

endmodule

// File: rtl/srrDatapath.sv
module srrDatapath #(
  parameter int IN_W    = 16,
  parameter int MODULUS = 17,
  parameter int RES_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  srrPkg::srrStrobe_t strobe,
  input  logic [IN_W-1:0]    dataIn,
  output logic [RES_W-1:0]   residueOut
);
  localparam int HALF_W = IN_W / 2;
  localparam int SUM_W  = RES_W + 1;
  localparam logic [SUM_W-1:0] MOD_SUM = SUM_W'(MODULUS);

  logic [HALF_W-1:0] upperHalf;
  logic [HALF_W-1:0] lowerHalf;
  logic [RES_W-1:0]  corrRead;
  logic [RES_W-1:0]  offsRead;
  logic [RES_W-1:0]  corrQ;
  logic [RES_W-1:0]  offsQ;
  logic [SUM_W-1:0]  sumQ;
  logic [RES_W-1:0]  foldD;
  logic [RES_W-1:0]  resQ;

  assign upperHalf = dataIn[IN_W-1:HALF_W];
  assign lowerHalf = dataIn[HALF_W-1:0];

  // Correction per subrange: first value of the subrange, reduced.
  srrTable #(.ADDR_W(HALF_W), .RES_W(RES_W), .MODULUS(MODULUS), .SHIFT(HALF_W))
    i_corrTable (.addr(upperHalf), .data(corrRead));

  // Offset inside the subrange, reduced.
  srrTable #(.ADDR_W(HALF_W), .RES_W(RES_W), .MODULUS(MODULUS), .SHIFT(0))
    i_offsTable (.addr(lowerHalf), .data(offsRead));

  always_ff @(posedge clk) begin
    if (rst) begin
      corrQ <= '0;
      offsQ <= '0;
    end else if (strobe.capTable) begin
      corrQ <= corrRead;
      offsQ <= offsRead;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumQ <= '0;
    end else if (strobe.capSum) begin
      sumQ <= {1'b0, corrQ} + {1'b0, offsQ};
    end
  end

  // Both addends are below MODULUS, so one subtraction suffices.
  always_comb begin
    if (sumQ >= MOD_SUM) begin
      foldD = RES_W'(sumQ - MOD_SUM);
    end else begin
      foldD = sumQ[RES_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resQ <= '0;
    end else if (strobe.capFold) begin
      resQ <= foldD;
    end
  end

  assign residueOut = resQ;

endmodule

// File: rtl/subrangeResidue.sv
module subrangeResidue #(
  parameter int  IN_W    = 16,
  parameter int  MODULUS = 17,
  localparam int RES_W   = $clog2(MODULUS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             validIn,
  input  logic [IN_W-1:0]  dataIn,
  output logic             validOut,
  output logic [RES_W-1:0] residueOut
);
  srrPkg::srrStrobe_t strobe;

  srrCtrl #(.STAGES(3)) i_srrCtrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  srrDatapath #(.IN_W(IN_W), .MODULUS(MODULUS), .RES_W(RES_W)) i_srrDatapath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .dataIn     (dataIn),
    .residueOut (residueOut)
  );

endmodule

// File: rtl/srrChecker.sv
module srrChecker #(
  parameter int IN_W    = 16,
  parameter int MODULUS = 17,
  parameter int RES_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             validIn,
  input logic [IN_W-1:0]  dataIn,
  input logic             validOut,
  input logic [RES_W-1:0] residueOut
);
  logic [2:0]      vTrack;
  logic [IN_W-1:0] dTrack [3];
  logic            rstSeen;

  always_ff @(posedge clk) begin
    rstSeen <= rst;
    if (rst) begin
      vTrack <= '0;
      for (int k = 0; k < 3; k++) dTrack[k] <= '0;
    end else begin
      vTrack    <= {vTrack[1:0], validIn};
      dTrack[0] <= dataIn;
      dTrack[1] <= dTrack[0];
      dTrack[2] <= dTrack[1];
    end
  end

  // R1: state right after a reset edge
  always_ff @(posedge clk) begin
    if (rstSeen) begin
      assert_reset_state_R1: assert (!validOut && residueOut == '0);
    end
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    validOut == vTrack[2]);

  assert_value_R2: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (longint'(residueOut) == longint'(dTrack[2]) % longint'(MODULUS)));

  assert_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (longint'(residueOut) < longint'(MODULUS)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> $stable(residueOut));

endmodule

bind subrangeResidue srrChecker #(.IN_W(IN_W), .MODULUS(MODULUS), .RES_W(RES_W))
  i_srrChecker (
    .clk        (clk),
    .rst        (rst),
    .validIn    (validIn),
    .dataIn     (dataIn),
    .validOut   (validOut),
    .residueOut (residueOut)
  );

// File: tb/test_subrangeResidue.sv
`timescale 1ns/1ps
module test_subrangeResidue;
  localparam int BIG_W = 16;
  localparam int BIG_P = 17;
  localparam int SML_W = 8;
  localparam int SML_P = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validIn = 1'b0;
  logic [BIG_W-1:0] dataIn = '0;
  logic bigValid, smlValid;
  logic [$clog2(BIG_P)-1:0] bigRes;
  logic [$clog2(SML_P)-1:0] smlRes;

  int total = 0;
  int bad = 0;
  string curTag = "R2";

  // model state
  bit mvB [3];
  int mdB [3];
  int lastB = 0;
  int mdS [3];
  int lastS = 0;

  always #4 clk = ~clk;

  subrangeResidue #(.IN_W(BIG_W), .MODULUS(BIG_P)) i_subrangeResidue (
    .clk(clk), .rst(rst), .validIn(validIn), .dataIn(dataIn),
    .validOut(bigValid), .residueOut(bigRes));

  subrangeResidue #(.IN_W(SML_W), .MODULUS(SML_P)) i_subrangeResidueSmall (
    .clk(clk), .rst(rst), .validIn(validIn), .dataIn(dataIn[SML_W-1:0]),
    .validOut(smlValid), .residueOut(smlRes));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d data=%0d", tag, act, exp, dataIn);
    end
  endtask

  task automatic step(input bit v, input int d);
    @(negedge clk);
    validIn = v;
    dataIn  = BIG_W'(d);
    @(posedge clk);
    mvB[2] = mvB[1]; mvB[1] = mvB[0]; mvB[0] = v;
    mdB[2] = mdB[1]; mdB[1] = mdB[0]; mdB[0] = d % (1 << BIG_W);
    mdS[2] = mdS[1]; mdS[1] = mdS[0]; mdS[0] = d % (1 << SML_W);
    if (mvB[2]) begin
      lastB = mdB[2] % BIG_P;
      lastS = mdS[2] % SML_P;
    end
    #1;
    check("R3", int'(bigValid), int'(mvB[2]));
    check("R3", int'(smlValid), int'(mvB[2]));
    if (mvB[2]) begin
      check(curTag, int'(bigRes), lastB);
      check("R5", int'(bigRes < BIG_P), 1);
      check("R8", int'(smlRes), lastS);
    end else begin
      check("R6", int'(bigRes), lastB);
      check("R6", int'(smlRes), lastS);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    bad++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin mvB[k] = 0; mdB[k] = 0; mdS[k] = 0; end
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(bigValid), 0);
    check("R1", int'(bigRes), 0);
    check("R1", int'(smlValid), 0);
    rst = 1'b0;
    step(0, 0);
    check("R1", int'(bigValid), 0);
    check("R1", int'(bigRes), 0);

    // R9: subrange starts, lower half zero
    curTag = "R9";
    for (int h = 0; h < 256; h++) step(1, h << 8);

    // R2 on the big instance; exhaustive input space of the small one (R8)
    curTag = "R2";
    for (int i = 0; i < 256; i++) step(1, i);

    // R7: corners and multiples of the modulus
    curTag = "R7";
    step(1, 0);
    step(1, 65535);
    step(1, 65534);
    step(1, 32768);
    for (int m = 0; m < 3856; m += 97) step(1, m * BIG_P);
    step(1, 3855 * BIG_P);

    // R6: idle cycles with changing data must not disturb the outputs
    curTag = "R6";
    step(1, 12345);
    for (int i = 0; i < 8; i++) step(0, int'($urandom_range(0, 65535)));
    step(1, 40000);
    for (int i = 0; i < 5; i++) step(0, 65535 - i);

    // R4: back-to-back random stream
    curTag = "R4";
    for (int i = 0; i < 3000; i++) step(1, int'($urandom_range(0, 65535)));
    // mixed gaps
    curTag = "R2";
    for (int i = 0; i < 1000; i++) step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 65535)));
    for (int i = 0; i < 4; i++) step(0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule